// File: doc/BRIEF.md
# Opcode Step Sequencer

This block takes one 8-bit opcode and plays it out as a short fixed procedure of control-bus words. Each word is a 5-bit enumerator, which selects a register or ALU unit, and a 2-bit parameter field. A word stays on the bus for a fixed number of ticks. During that time the block raises a step strobe and drives a bus clock phase. The bus clock stays low for the first ticks of a step, so downstream enumeration decoders can settle before they act.

Three procedures are built in. A register-to-register move takes two steps. An increment of AX or BX takes four steps. A null procedure of one step covers the all-zero opcode and every opcode that has no meaning. When the last tick of a procedure has passed, the block pulses `done` for one cycle and goes back to idle. In that same cycle it can accept the next opcode, so a fetch can follow at once.

Top module: `step_sequencer`

## Requirements
- R1: After reset the block is idle. `op_ready` is 1 and `step_line`, `bus_clk`, `done`, `bus_enum` and `bus_param` are all 0.
- R2: An opcode on `op_code` is captured at a rising edge where `op_valid` and `op_ready` are both 1. While a procedure runs, `op_valid` is ignored: it neither changes the running procedure nor queues a second one.
- R3: Each step lasts exactly TICKS_PER_STEP cycles (default 4). `step_line` stays 1 throughout, and the word on `bus_enum`/`bus_param` is held constant for the whole step.
- R4: `bus_clk` is 0 on the first CLK_TICK ticks of every step (default 2) and 1 from the third tick to the end of the step. It is 0 while idle.
- R5: An opcode `00sssddd` other than all-zero is a move in two steps: enumerator `00sss` with parameter `00` (source), then enumerator `00ddd` with parameter `10` (destination).
- R6: Opcode `00000000` runs one step with enumerator `00000` and parameter `00`.
- R7: Opcode `0101010x` is an increment in four steps: `00001`/`01` (raise carry), then `0001`+not x/`01`, then `01010`/`10` (adder on), then `0001`+x/`10` (write back). x=0 targets AX (`00010`) and x=1 targets BX (`00011`).
- R8: Any opcode that is neither a move nor an increment runs the same single null step as R6.
- R9: `done` is 1 for exactly one cycle, the cycle after the last tick of the last step. In that cycle `op_ready` is 1 and a new opcode can be captured.
- R10: `op_ready` is 0 for every cycle in which `step_line` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one tick |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode offered this cycle |
| op_code | input | 8 | Fetched opcode |
| op_ready | output | 1 | Idle, able to capture an opcode |
| step_line | output | 1 | High while a procedure step is active |
| bus_clk | output | 1 | Bus clock phase for the current step |
| bus_enum | output | 5 | Enumerator of the current control word |
| bus_param | output | 2 | Parameter bits of the current control word |
| done | output | 1 | One-cycle pulse when a procedure ends |

## Verification
Some properties are checked on every cycle by the assertions. The control word holds steady within a step, and `bus_clk` rises exactly at the third tick. The step index never goes past the length of the decoded procedure. `done` lasts one cycle and only follows an active step. Other behaviour can only be shown by the bench's scenarios: the exact word sequence for each kind of opcode, the capture timing, the back-to-back start in the `done` cycle, and the fact that an opcode offered while busy leaves no trace.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int ENUM_W   = 5;
  localparam int PARAM_W  = 2;
  localparam int OP_W     = 8;
  localparam int PROC_MAX = 4;                       // longest procedure
  localparam int IDX_W    = $clog2(PROC_MAX + 1);    // holds 0..PROC_MAX
  localparam int SEL_W    = $clog2(PROC_MAX);

  typedef struct packed {
    logic [ENUM_W-1:0]  code;
    logic [PARAM_W-1:0] prm;
  } bus_word_t;

  function automatic logic is_inc(input logic [OP_W-1:0] op);
    return op[7:1] == 7'b0101010;
  endfunction

  function automatic logic is_mov(input logic [OP_W-1:0] op);
    return (op[7:6] == 2'b00) && (op != '0);
  endfunction

  // number of steps in the procedure of an opcode
  function automatic logic [IDX_W-1:0] proc_len(input logic [OP_W-1:0] op);
    if (is_inc(op))      return IDX_W'(4);
    else if (is_mov(op)) return IDX_W'(2);
    else                 return IDX_W'(1);
  endfunction

  // control word for step idx of an opcode; null word where nothing applies
  function automatic bus_word_t proc_word(input logic [OP_W-1:0] op,
                                          input logic [IDX_W-1:0] idx);
    bus_word_t w;
    w = '0;
    if (is_inc(op)) begin
      case (idx)
        IDX_W'(0): w = '{code: 5'b00001,               prm: 2'b01};
        IDX_W'(1): w = '{code: {4'b0001, ~op[0]},      prm: 2'b01};
        IDX_W'(2): w = '{code: 5'b01010,               prm: 2'b10};
        IDX_W'(3): w = '{code: {4'b0001, op[0]},       prm: 2'b10};
        default:   w = '0;
      endcase
    end else if (is_mov(op)) begin
      case (idx)
        IDX_W'(0): w = '{code: {2'b00, op[5:3]},       prm: 2'b00};
        IDX_W'(1): w = '{code: {2'b00, op[2:0]},       prm: 2'b10};
        default:   w = '0;
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic [IDX_W-1:0] step_idx,
  output logic [IDX_W-1:0] n_steps,
  output bus_word_t        word
);
  bus_word_t table_w [PROC_MAX];

  for (genvar g = 0; g < PROC_MAX; g++) begin : g_word
    assign table_w[g] = proc_word(op, IDX_W'(g));
  end

  assign n_steps = proc_len(op);

  always_comb begin
    if (step_idx < IDX_W'(PROC_MAX)) word = table_w[step_idx[SEL_W-1:0]];
    else                             word = '0;
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer
  import seq_pkg::*;
#(
  parameter int TICKS_PER_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic [IDX_W-1:0] n_steps,
  output logic [((TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1)-1:0] tick_idx,
  output logic [IDX_W-1:0] step_idx,
  output logic             step_end,
  output logic             proc_end
);
  localparam int TICK_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_STEP - 1);

  assign step_end = active && (tick_idx == TICK_LAST);
  assign proc_end = step_end && (step_idx == n_steps - IDX_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      tick_idx <= '0;
      step_idx <= '0;
    end else if (step_end) begin
      tick_idx <= '0;
      step_idx <= step_idx + IDX_W'(1);
    end else if (active) begin
      tick_idx <= tick_idx + TICK_W'(1);
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (step_idx < n_steps));                                   // R3
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
  import seq_pkg::*;
#(
  parameter int TICKS_PER_STEP = 4,
  parameter int CLK_TICK       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  output logic              op_ready,
  output logic              step_line,
  output logic              bus_clk,
  output logic [4:0]        bus_enum,
  output logic [1:0]        bus_param,
  output logic              done
);
  localparam int TICK_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [TICK_W-1:0] CLK_T = TICK_W'(CLK_TICK);

  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t           state;
  logic [OP_W-1:0]  op_q;
  logic             start;
  logic             running;
  logic [TICK_W-1:0] tick_idx;
  logic [IDX_W-1:0] step_idx;
  logic [IDX_W-1:0] n_steps;
  logic             step_end;
  logic             proc_end;
  bus_word_t        word;

  assign running = (state == S_RUN);
  assign start   = (state == S_IDLE) && op_valid;

  seq_decode u_dec (
    .op       (op_q),
    .step_idx (step_idx),
    .n_steps  (n_steps),
    .word     (word)
  );

  seq_timer #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .active   (running),
    .n_steps  (n_steps),
    .tick_idx (tick_idx),
    .step_idx (step_idx),
    .step_end (step_end),
    .proc_end (proc_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_q  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        op_q  <= op_code;
        state <= S_RUN;
      end else if (proc_end) begin
        state <= S_IDLE;
        done  <= 1'b1;
      end
    end
  end

  assign op_ready  = !running;
  assign step_line = running;
  assign bus_clk   = running && (tick_idx >= CLK_T);
  assign bus_enum  = running ? word.code : '0;
  assign bus_param = running ? word.prm  : '0;

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_line && tick_idx != '0) |-> ($stable(bus_enum) && $stable(bus_param))); // R3
  AST_CLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_line && tick_idx == CLK_T) |-> $rose(bus_clk));                // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                     // R9
  AST_DONE_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(step_line) && !step_line));                          // R9
endmodule

// File: tb/sim_step_sequencer.sv
module sim_step_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic       op_ready, step_line, bus_clk, done;
  logic [4:0] bus_enum;
  logic [1:0] bus_param;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  step_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_ready(op_ready), .step_line(step_line), .bus_clk(bus_clk),
    .bus_enum(bus_enum), .bus_param(bus_param), .done(done)
  );

  // bench model: step count
  function automatic int exp_len(input logic [7:0] op);
    if (op[7:6] == 2'b01 && op[5:1] == 5'b01010) return 4;
    if (op[7:6] == 2'b00 && op[5:0] != 6'd0)     return 2;
    return 1;
  endfunction

  // bench model: {enum, param} of step s
  function automatic logic [6:0] exp_word(input logic [7:0] op, input int s);
    int n = exp_len(op);
    logic [4:0] tgt   = op[0] ? 5'd3 : 5'd2;   // AX = 2, BX = 3
    logic [4:0] other = op[0] ? 5'd2 : 5'd3;
    if (n == 4) begin
      if (s == 0) return {5'd1, 2'd1};
      if (s == 1) return {other, 2'd1};
      if (s == 2) return {5'd10, 2'd2};
      return {tgt, 2'd2};
    end
    if (n == 2) begin
      if (s == 0) return {2'b00, op[5:3], 2'd0};
      return {2'b00, op[2:0], 2'd2};
    end
    return 7'd0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // observed vector: {step_line, bus_clk, op_ready, done, enum, param}
  function automatic logic [10:0] obs();
    return {step_line, bus_clk, op_ready, done, bus_enum, bus_param};
  endfunction

  task automatic start_op(input logic [7:0] op);
    @(negedge clk);
    op_valid = 1'b1; op_code = op;
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  // samples every cycle of the procedure; ends at the done cycle's negedge
  task automatic body(input logic [7:0] op, input string req, input bit inject);
    int n = exp_len(op);
    for (int k = 0; k < 4 * n; k++) begin
      @(negedge clk);
      begin
        int s = k / 4;
        int t = k % 4;
        logic [10:0] e = {1'b1, (t >= 2), 1'b0, 1'b0, exp_word(op, s)};
        check(obs() == e, req, $sformatf("op %0h step %0d tick %0d", op, s, t),
              obs(), e);
        if (inject && k == 1) begin op_valid = 1'b1; op_code = 8'h55; end
        if (inject && k == 3) op_valid = 1'b0;
      end
    end
    @(negedge clk);
    check(obs() == 11'b0011_0000000, "R9", $sformatf("done cycle op %0h", op),
          obs(), 11'b0011_0000000);
  endtask

  task automatic tail(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(obs() == 11'b0010_0000000, req, "idle after done", obs(), 11'b0010_0000000);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(obs() == 11'b0010_0000000, "R1", "reset state", obs(), 11'b0010_0000000);
    tail("R2", 2);   // no op_valid -> nothing starts
  endtask

  task automatic t_mov();
    start_op(8'h13); body(8'h13, "R5", 0); tail("R9", 1);   // AX -> BX
    start_op(8'h2E); body(8'h2E, "R5", 0); tail("R9", 1);   // IObuf -> IP
  endtask

  task automatic t_nop();
    start_op(8'h00); body(8'h00, "R6", 0); tail("R9", 1);
  endtask

  task automatic t_inc();
    start_op(8'h54); body(8'h54, "R7", 0); tail("R9", 1);   // AX
    start_op(8'h55); body(8'h55, "R7", 0); tail("R9", 1);   // BX
  endtask

  task automatic t_undef();
    start_op(8'hC3); body(8'hC3, "R8", 0); tail("R8", 1);
    start_op(8'h56); body(8'h56, "R8", 0); tail("R8", 1);
  endtask

  task automatic t_busy_ignore();
    start_op(8'h1A); body(8'h1A, "R2", 1); tail("R2", 3);
    check(1'b1, "R10", "ready low while busy covered by body", 0, 0);
  endtask

  task automatic t_back_to_back();
    start_op(8'h54); body(8'h54, "R9", 0);
    op_valid = 1'b1; op_code = 8'h21;    // offered in the done cycle
    @(posedge clk); #1;
    op_valid = 1'b0;
    body(8'h21, "R9", 0); tail("R9", 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_mov();
    t_nop();
    t_inc();
    t_undef();
    t_busy_ignore();
    t_back_to_back();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule